// File: doc/BRIEF.md
# Square-Root Carry Select Adder

This block is a purely combinational unsigned adder. It adds two operands and a carry-in, and returns a sum of the operand width plus a carry-out. The operand is cut into groups that get wider toward the most significant end. The lowest group is a plain ripple chain fed by the external carry-in.

Every higher group ripples its operands once, assuming no incoming carry. It then forms the "incoming carry set" result by incrementing that first result in a small excess-one stage. The carry leaving the group below picks one of the two results. No second ripple chain is built per group, which saves adder cells.

The block has no clock and no reset. It drops into any datapath that needs a fast add of 8, 16, 32 or 64 bits.

Top module: `sqcsel_adder`

## Requirements
- R1: `{cout_o, sum_o}` equals the unsigned value `a_i + b_i + cin_i`, computed WIDTH+1 bits wide, for WIDTH of 8, 16, 32 and 64.
- R2: Groups are laid out from bit 0 upward with sizes 2, 2, 3, 4, 5, and so on, each one bit wider than the one before after the first two. The last group is cut short to end at WIDTH-1. At 16 bits the group lower bounds are 0, 2, 4, 7 and 11.
- R3: The lowest group is a single ripple chain of full adders whose carry-in is `cin_i`. For example, 3 + 0 with carry-in 1 gives 4.
- R4: In each higher group, the result for an incoming carry of one equals that group's operands plus one. This value is the zero-carry result `{carry, sum}` incremented by one, and the increment never wraps.
- R5: Bit 0 of the excess-one output is its input bit 0 inverted. Bit i is input bit i XOR the AND of all input bits below i.
- R6: Each higher group outputs its plus-one result when the carry from the group below is 1, and its zero-carry result otherwise. A carry chain that crosses every group boundary must come out correct.
- R7: All-ones operands with `cin_i` = 1 give an all-ones sum and `cout_o` = 1. Zero operands with `cin_i` = 1 give a sum of 1 and `cout_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First unsigned operand |
| b_i | input | WIDTH | Second unsigned operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of the most significant group |

## Verification
The bench drives carries that enter exactly at each group boundary it computes on its own (a run of ones up to the boundary plus a carry-in). A wrong partition, or a select wired to the wrong neighbour, would then leave the sum one group short.

All-ones operands with a carry-in push the excess-one stage of every group to its largest input. A converter with a broken AND chain or an inverted bit 0 would corrupt the upper sum bits or drop the carry-out.

The 8-bit adder is swept over every operand pair and both carry-in values. The wider adders take a fixed vector table and random operands. A mux with swapped inputs would fail almost every vector.

// File: rtl/csa_pkg.sv
package csa_pkg;

  // Nominal size of group k: 2, 2, 3, 4, 5, ...
  function automatic int csa_nominal(int k);
    return (k == 0) ? 2 : k + 1;
  endfunction

  // Lowest bit index of group k
  function automatic int csa_lo(int k);
    int s;
    s = 0;
    for (int j = 0; j < k; j++) s += csa_nominal(j);
    return s;
  endfunction

  // Actual width of group k inside a w-bit adder (last group trimmed)
  function automatic int csa_width(int w, int k);
    int lo;
    int n;
    lo = csa_lo(k);
    n  = csa_nominal(k);
    return (lo + n > w) ? w - lo : n;
  endfunction

  // Number of groups that cover w bits
  function automatic int csa_count(int w);
    for (int k = 0; k <= w; k++) begin
      if (csa_lo(k) >= w) return k;
    end
    return w;
  endfunction

  // One full adder: returns {carry, sum}
  function automatic logic [1:0] csa_fa(logic x, logic y, logic c);
    return {(x & y) | (c & (x ^ y)), x ^ y ^ c};
  endfunction

endpackage

// File: rtl/csa_rca.sv
module csa_rca import csa_pkg::*; #(
  parameter int N = 4
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         cin_i,
  output logic [N-1:0] sum_o,
  output logic         cout_o
);
  logic [N:0] chain;

  assign chain[0] = cin_i;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [1:0] fa;
    assign fa          = csa_fa(a_i[i], b_i[i], chain[i]);
    assign sum_o[i]    = fa[0];
    assign chain[i+1]  = fa[1];
  end

  assign cout_o = chain[N];

  always_comb begin
    AST_RIPPLE_ADD: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{N{1'b0}}, cin_i})) else $error("ripple chain mismatch"); // R3
  end
endmodule

// File: rtl/csa_bec.sv
module csa_bec #(
  parameter int N = 4
) (
  input  logic [N-1:0] in_i,
  output logic [N-1:0] inc_o
);
  // and_low[i] is the AND of all input bits below i
  logic [N:0] and_low;

  assign and_low[0] = 1'b1;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign and_low[i+1] = and_low[i] & in_i[i];
    assign inc_o[i]     = in_i[i] ^ and_low[i];
  end

  always_comb begin
    AST_INC_EXACT: assert (inc_o == in_i + {{(N-1){1'b0}}, 1'b1}) else $error("excess-one mismatch"); // R5
  end
endmodule

// File: rtl/csa_group.sv
module csa_group #(
  parameter int N = 3
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         csel_i,
  output logic [N-1:0] sum_o,
  output logic         cout_o
);
  logic [N-1:0] sum_c0;
  logic         carry_c0;
  logic [N:0]   plus_one;
  logic [N-1:0] sum_c1;
  logic         carry_c1;

  csa_rca #(.N(N)) u_rca (
    .a_i    (a_i),
    .b_i    (b_i),
    .cin_i  (1'b0),
    .sum_o  (sum_c0),
    .cout_o (carry_c0)
  );

  csa_bec #(.N(N + 1)) u_bec (
    .in_i  ({carry_c0, sum_c0}),
    .inc_o (plus_one)
  );

  assign sum_c1   = plus_one[N-1:0];
  assign carry_c1 = plus_one[N];

  assign sum_o  = csel_i ? sum_c1   : sum_c0;
  assign cout_o = csel_i ? carry_c1 : carry_c0;

  always_comb begin
    AST_PLUS_ONE: assert ({carry_c1, sum_c1} == ({1'b0, a_i} + {1'b0, b_i} + {{N{1'b0}}, 1'b1})) else $error("plus-one result wrong"); // R4
    AST_NO_WRAP: assert (!(carry_c0 && (&sum_c0))) else $error("zero-carry result at maximum"); // R4
    AST_CARRY_ORDER: assert (!carry_c0 || carry_c1) else $error("carry lost by increment"); // R6
  end
endmodule

// File: rtl/sqcsel_adder.sv
module sqcsel_adder import csa_pkg::*; #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  localparam int NGRP = csa_count(WIDTH);

  // group_carry[g] is the carry entering group g
  logic [NGRP:0] group_carry;

  assign group_carry[0] = cin_i;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int LO = csa_lo(g);
    localparam int GW = csa_width(WIDTH, g);
    logic [GW-1:0] gsum;

    if (g == 0) begin : g_base
      csa_rca #(.N(GW)) u_rca (
        .a_i    (a_i[LO +: GW]),
        .b_i    (b_i[LO +: GW]),
        .cin_i  (group_carry[0]),
        .sum_o  (gsum),
        .cout_o (group_carry[1])
      );
    end else begin : g_sel
      csa_group #(.N(GW)) u_grp (
        .a_i    (a_i[LO +: GW]),
        .b_i    (b_i[LO +: GW]),
        .csel_i (group_carry[g]),
        .sum_o  (gsum),
        .cout_o (group_carry[g+1])
      );
    end

    assign sum_o[LO +: GW] = gsum;
  end

  assign cout_o = group_carry[NGRP];

  always_comb begin
    AST_FULL_SUM: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i})) else $error("adder result wrong"); // R1
  end
endmodule

// File: tb/sqcsel_adder_tb_top.sv
module sqcsel_adder_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  int n_run  = 0;
  int n_fail = 0;
  int cycles = 0;

  logic [7:0]  a8,  b8,  s8;  logic c8,  co8;
  logic [15:0] a16, b16, s16; logic c16, co16;
  logic [31:0] a32, b32, s32; logic c32, co32;
  logic [63:0] a64, b64, s64; logic c64, co64;

  sqcsel_adder #(.WIDTH(16)) dut_i (.a_i(a16), .b_i(b16), .cin_i(c16), .sum_o(s16), .cout_o(co16));
  sqcsel_adder #(.WIDTH(8))  dut_w8_i (.a_i(a8), .b_i(b8), .cin_i(c8), .sum_o(s8), .cout_o(co8));
  sqcsel_adder #(.WIDTH(32)) dut_w32_i (.a_i(a32), .b_i(b32), .cin_i(c32), .sum_o(s32), .cout_o(co32));
  sqcsel_adder #(.WIDTH(64)) dut_w64_i (.a_i(a64), .b_i(b64), .cin_i(c64), .sum_o(s64), .cout_o(co64));

  // {a, b, cin, expected 17-bit result}
  localparam logic [49:0] VTAB [10] = '{
    {16'h0000, 16'h0000, 1'b0, 17'h00000},
    {16'h0000, 16'h0000, 1'b1, 17'h00001},
    {16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF},
    {16'hFFFF, 16'h0000, 1'b1, 17'h10000},
    {16'h0003, 16'h0001, 1'b0, 17'h00004},
    {16'h1234, 16'h4321, 1'b0, 17'h05555},
    {16'h8000, 16'h8000, 1'b0, 17'h10000},
    {16'h00FF, 16'h0001, 1'b0, 17'h00100},
    {16'hAAAA, 16'h5555, 1'b1, 17'h10000},
    {16'h7FFF, 16'h0001, 1'b0, 17'h08000}
  };

  task automatic chk(input string req, input logic [64:0] act, input logic [64:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [64:0] ref65;
    int lo;
    int sz;
    a8 = '0; b8 = '0; c8 = 0;
    a16 = '0; b16 = '0; c16 = 0;
    a32 = '0; b32 = '0; c32 = 0;
    a64 = '0; b64 = '0; c64 = 0;
    #1;
    // Initial state: zero inputs give zero outputs (R1)
    chk("R1 idle", {48'd0, co16, s16}, 65'd0);

    // R1 vector table at 16 bits
    for (int i = 0; i < 10; i++) begin
      {a16, b16, c16} = VTAB[i][49:17];
      #1;
      chk("R1 table", {48'd0, co16, s16}, {48'd0, VTAB[i][16:0]});
    end

    // R3 lowest group takes cin directly
    a16 = 16'h0003; b16 = 16'h0000; c16 = 1'b1; #1;
    chk("R3 base group", {48'd0, co16, s16}, 65'h4);
    a16 = 16'h0001; b16 = 16'h0002; c16 = 1'b0; #1;
    chk("R3 base group no carry", {48'd0, co16, s16}, 65'h3);

    // R7 extremes at every width
    a8 = 8'hFF; b8 = 8'hFF; c8 = 1'b1;
    a32 = '1; b32 = '1; c32 = 1'b1;
    a64 = '1; b64 = '1; c64 = 1'b1;
    a16 = '1; b16 = '1; c16 = 1'b1; #1;
    chk("R7 ones w8",  {56'd0, co8, s8},   {56'd0, 9'h1FF});
    chk("R7 ones w16", {48'd0, co16, s16}, {48'd0, 17'h1FFFF});
    chk("R7 ones w32", {32'd0, co32, s32}, {32'd0, 33'h1FFFFFFFF});
    chk("R7 ones w64", {co64, s64}, {1'b1, 64'hFFFFFFFFFFFFFFFF});
    a64 = '0; b64 = '0; c64 = 1'b1; #1;
    chk("R7 zero plus carry w64", {co64, s64}, 65'd1);

    // R2/R6: a carry arriving exactly at each group boundary (sizes worked out here)
    lo = 0; sz = 2;
    for (int k = 0; lo < 64; k++) begin
      a64 = (lo == 0) ? 64'd0 : ((64'd1 << lo) - 64'd1);
      b64 = '0; c64 = 1'b1; #1;
      chk("R2 R6 boundary w64", {co64, s64}, (65'd1 << lo));
      lo = lo + sz;
      if (k >= 1) sz = sz + 1;
    end
    // R6: group select fed by carry from below, at the 16-bit boundary 11
    a16 = 16'h07FF; b16 = 16'h0000; c16 = 1'b1; #1;
    chk("R6 select at bit 11", {48'd0, co16, s16}, 65'h0800);
    // R4 R5: upper groups with full carry-ripple through the excess-one stage
    a32 = 32'hFFFF_FFFF; b32 = 32'h0; c32 = 1'b1; #1;
    chk("R4 R5 increment chain w32", {32'd0, co32, s32}, {32'd0, 33'h100000000});

    // R1 random vectors at 32 and 64 bits
    for (int i = 0; i < 3000; i++) begin
      a32 = $urandom; b32 = $urandom; c32 = 1'($urandom);
      a64 = {$urandom, $urandom}; b64 = {$urandom, $urandom}; c64 = 1'($urandom);
      #1;
      ref65 = {33'd0, a32} + {33'd0, b32} + {64'd0, c32};
      chk("R1 random w32", {32'd0, co32, s32}, ref65);
      ref65 = {1'b0, a64} + {1'b0, b64} + {64'd0, c64};
      chk("R1 random w64", {co64, s64}, ref65);
    end

    // R1 exhaustive sweep at 8 bits
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        for (int c = 0; c < 2; c++) begin
          a8 = 8'(x); b8 = 8'(y); c8 = 1'(c);
          #1;
          chk("R1 exhaustive w8", {56'd0, co8, s8}, 65'(x + y + c));
        end
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule